// File: doc/BRIEF.md
# Two-Wire Bus Controller Interrupt Request Logic

This block sits between a processor register bus and a two-wire (I2C) master bit engine. It holds a command/status register and a data register, and keeps one sticky interrupt request for the processor. The request is raised by two events from the engine. The first is the engine reporting that it is ready for a new command, seen as its `eng_done` flag going from 0 to 1. The second, which has its own enable, is the end of a stop condition, seen as `eng_stop` going from 1 to 0.

Firmware clears the request in two ways. It can write a zero to the request bit of a flag register. The request is also cleared, as a side effect, by any read or accepted write of the command/status or data register. While the engine is driving a stop condition, writes to those two registers have no effect at all. When both sources are enabled, firmware tells them apart by reading the done and stop bits of the status register. There is no separate source register.

Registers are selected by `bus_sel` with `bus_addr`. Writes take effect at the clock edge. Read data is combinational from the current address and state.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `irq`, `tx_wr`, `rx_rd`, `cmd_start` and `cmd_stop` are 0. The enable register (ENAB_ADDR) reads 0, the flag register (FLAG_ADDR) reads 0, and `cmd_lastrd` is 0.
- R2: A read of the status register at CTRL_ADDR returns these fields:
  - bit 7: 0
  - bit 6: `eng_stop`
  - bit 5: the stored last-read bit
  - bits 4:3: `eng_id`
  - bit 2: `eng_berr`
  - bit 1: `eng_ack`
  - bit 0: `eng_done`

  A read of the data register at CTRL_ADDR+1 returns `eng_rx_byte`. Unmapped addresses read 0.
- R3: A 0-to-1 change of `eng_done` between two consecutive clock samples sets the request at that clock edge, whatever the stop enable holds.
- R4: A 1-to-0 change of `eng_stop` sets the request only when the stop enable (bit 1 of the enable register) is 1. When that bit is 0, the change leaves the request as it was.
- R5: `irq` equals the request ANDed with the main enable (bit 0 of the enable register). A read of the flag register returns the request in bit REQ_BIT, independent of the enables, and does not clear it.
- R6: A write to the flag register with bit REQ_BIT = 0 clears the request. A write with that bit = 1 leaves the request unchanged.
- R7: Any read, and any accepted write, of the status or data register clears the request at that clock edge.
- R8: When a set event from R3 or R4 falls in the same cycle as a clearing access from R6 or R7, the request ends the cycle set.
- R9: While `eng_stop` is 1, writes to the status or data register are dropped. They produce no `tx_wr`, `cmd_start` or `cmd_stop` pulse, they leave `tx_byte` and `cmd_lastrd` unchanged, and they do not clear the request.
- R10: An accepted data write loads `tx_byte` and pulses `tx_wr` for one cycle after the edge. An accepted status write stores bit 5 into `cmd_lastrd` and pulses `cmd_start` for bit 7 and `cmd_stop` for bit 6. A data read pulses `rx_rd` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| eng_done | input | 1 | Engine ready for next command |
| eng_stop | input | 1 | Engine is generating a stop condition |
| eng_ack | input | 1 | Acknowledge seen on last byte |
| eng_berr | input | 1 | Bus error flag |
| eng_id | input | 2 | Engine identification bits |
| eng_rx_byte | input | 8 | Last received byte |
| cmd_start | output | 1 | One-cycle start command to engine |
| cmd_stop | output | 1 | One-cycle stop command to engine |
| cmd_lastrd | output | 1 | Stored last-read flag |
| tx_byte | output | 8 | Byte to transmit |
| tx_wr | output | 1 | One-cycle pulse: tx_byte newly loaded |
| rx_rd | output | 1 | One-cycle pulse: received byte consumed |
| irq | output | 1 | Interrupt request to processor |

## Verification
The assertions assume that the engine flags and the bus inputs are steady around each rising clock edge, and that only one register access is made per cycle. They also assume that `eng_done` and `eng_stop` are level flags whose history starts from 0 at reset. The bench changes every input 1 ns after a rising edge and checks read data at mid-cycle. Its random phase toggles the engine flags independently of the bus accesses, so set events and clearing accesses often fall in the same cycle, and writes often arrive while a stop is in progress.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int DATA_W = 8;

    // status register field positions (decoded by firmware)
    localparam int SB_START  = 7;
    localparam int SB_STOP   = 6;
    localparam int SB_LASTRD = 5;
    localparam int SB_ID_HI  = 4;
    localparam int SB_ID_LO  = 3;
    localparam int SB_BERR   = 2;
    localparam int SB_ACK    = 1;
    localparam int SB_DONE   = 0;

    // enable register field positions
    localparam int EB_MAIN = 0;
    localparam int EB_STOP = 1;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTRL,
        RS_DATA,
        RS_FLAG,
        RS_ENAB
    } rsel_e;

    typedef struct packed {
        logic              en_main;
        logic              en_stop;
        logic              lastrd;
        logic [DATA_W-1:0] tx_byte;
        logic              tx_wr;
        logic              cmd_start;
        logic              cmd_stop;
        logic              rx_rd;
    } top_state_t;

endpackage

// File: rtl/i2c_irq_edge.sv
module i2c_irq_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic evt_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    generate
        if (RISING) begin : g_rise
            assign evt_o = lvl_i & ~prev_q;
        end else begin : g_fall
            assign evt_o = ~lvl_i & prev_q;
        end
    endgenerate

    // an edge is a single-cycle event while the level holds
    p_edge_single_r3: assert property (@(posedge clk) disable iff (rst)
        (evt_o && (lvl_i == RISING)) |=> (!evt_o || (lvl_i != RISING)) || !$stable(lvl_i) || $past(rst))
        else $error("edge event held for more than one cycle");

endmodule

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
    import i2c_irq_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0040,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'h0050,
    parameter logic [ADDR_W-1:0] ENAB_ADDR = 16'h0051
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              busy_i,
    output logic              ctrl_wr_o,
    output logic              data_wr_o,
    output logic              ctrl_rd_o,
    output logic              data_rd_o,
    output logic              flag_wr_o,
    output logic              enab_wr_o,
    output rsel_e             rsel_o
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = CTRL_ADDR + 1'b1;

    logic hit_ctrl, hit_data, hit_flag, hit_enab;

    always_comb begin
        hit_ctrl = bus_sel && (bus_addr == CTRL_ADDR);
        hit_data = bus_sel && (bus_addr == DATA_ADDR);
        hit_flag = bus_sel && (bus_addr == FLAG_ADDR);
        hit_enab = bus_sel && (bus_addr == ENAB_ADDR);

        // writes to the engine-facing registers are dropped during a stop
        ctrl_wr_o = hit_ctrl && bus_we && !busy_i;
        data_wr_o = hit_data && bus_we && !busy_i;
        ctrl_rd_o = hit_ctrl && !bus_we;
        data_rd_o = hit_data && !bus_we;
        flag_wr_o = hit_flag && bus_we;
        enab_wr_o = hit_enab && bus_we;

        if (hit_ctrl)      rsel_o = RS_CTRL;
        else if (hit_data) rsel_o = RS_DATA;
        else if (hit_flag) rsel_o = RS_FLAG;
        else if (hit_enab) rsel_o = RS_ENAB;
        else               rsel_o = RS_NONE;
    end

    // decoded strobes never overlap
    always_comb begin
        a_onehot_r9: assert ($onehot0({ctrl_wr_o, data_wr_o, ctrl_rd_o, data_rd_o, flag_wr_o, enab_wr_o}))
            else $error("decoded strobes overlap");
    end

endmodule

// File: rtl/i2c_irq_reqflag.sv
module i2c_irq_reqflag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic req_o
);

    logic req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (clr_i) req_d = 1'b0;
        if (set_i) req_d = 1'b1;   // a set event outranks any clear
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_d;
    end

    assign req_o = req_q;

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set_i |=> req_o)
        else $error("set event lost");

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !req_o)
        else $error("clear not applied");

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> $stable(req_o))
        else $error("request changed with no cause");

endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
    import i2c_irq_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0040,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'h0050,
    parameter logic [ADDR_W-1:0] ENAB_ADDR = 16'h0051,
    parameter int                REQ_BIT   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              eng_done,
    input  logic              eng_stop,
    input  logic              eng_ack,
    input  logic              eng_berr,
    input  logic [1:0]        eng_id,
    input  logic [7:0]        eng_rx_byte,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_lastrd,
    output logic [7:0]        tx_byte,
    output logic              tx_wr,
    output logic              rx_rd,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = CTRL_ADDR + 1'b1;

    logic  ctrl_wr, data_wr, ctrl_rd, data_rd, flag_wr, enab_wr;
    rsel_e rsel;
    logic  done_rise, stop_fall;
    logic  req_set, req_clr, req;

    top_state_t st_d, st_q;

    i2c_irq_decode #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .FLAG_ADDR (FLAG_ADDR),
        .ENAB_ADDR (ENAB_ADDR)
    ) u_dec (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .busy_i    (eng_stop),
        .ctrl_wr_o (ctrl_wr),
        .data_wr_o (data_wr),
        .ctrl_rd_o (ctrl_rd),
        .data_rd_o (data_rd),
        .flag_wr_o (flag_wr),
        .enab_wr_o (enab_wr),
        .rsel_o    (rsel)
    );

    i2c_irq_edge #(.RISING(1'b1)) u_done_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (eng_done),
        .evt_o (done_rise)
    );

    i2c_irq_edge #(.RISING(1'b0)) u_stop_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (eng_stop),
        .evt_o (stop_fall)
    );

    always_comb begin
        req_set = done_rise || (stop_fall && st_q.en_stop);
        req_clr = ctrl_rd || data_rd || ctrl_wr || data_wr ||
                  (flag_wr && !bus_wdata[REQ_BIT]);
    end

    i2c_irq_reqflag u_req (
        .clk   (clk),
        .rst   (rst),
        .set_i (req_set),
        .clr_i (req_clr),
        .req_o (req)
    );

    // next-state computation
    always_comb begin
        st_d           = st_q;
        st_d.tx_wr     = 1'b0;
        st_d.cmd_start = 1'b0;
        st_d.cmd_stop  = 1'b0;
        st_d.rx_rd     = data_rd;
        if (enab_wr) begin
            st_d.en_main = bus_wdata[EB_MAIN];
            st_d.en_stop = bus_wdata[EB_STOP];
        end
        if (ctrl_wr) begin
            st_d.lastrd    = bus_wdata[SB_LASTRD];
            st_d.cmd_start = bus_wdata[SB_START];
            st_d.cmd_stop  = bus_wdata[SB_STOP];
        end
        if (data_wr) begin
            st_d.tx_byte = bus_wdata;
            st_d.tx_wr   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (rsel)
            RS_CTRL: begin
                bus_rdata[SB_STOP]           = eng_stop;
                bus_rdata[SB_LASTRD]         = st_q.lastrd;
                bus_rdata[SB_ID_HI:SB_ID_LO] = eng_id;
                bus_rdata[SB_BERR]           = eng_berr;
                bus_rdata[SB_ACK]            = eng_ack;
                bus_rdata[SB_DONE]           = eng_done;
            end
            RS_DATA: bus_rdata = eng_rx_byte;
            RS_FLAG: bus_rdata[REQ_BIT] = req;
            RS_ENAB: begin
                bus_rdata[EB_MAIN] = st_q.en_main;
                bus_rdata[EB_STOP] = st_q.en_stop;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign cmd_start  = st_q.cmd_start;
    assign cmd_stop   = st_q.cmd_stop;
    assign cmd_lastrd = st_q.lastrd;
    assign tx_byte    = st_q.tx_byte;
    assign tx_wr      = st_q.tx_wr;
    assign rx_rd      = st_q.rx_rd;
    assign irq        = req && st_q.en_main;

    p_drop_write_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && eng_stop &&
         (bus_addr == CTRL_ADDR || bus_addr == DATA_ADDR))
        |=> (!tx_wr && !cmd_start && !cmd_stop && $stable(cmd_lastrd) && $stable(tx_byte)))
        else $error("write accepted during stop");

    p_txwr_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_wr) |-> $past(bus_sel && bus_we && !eng_stop && bus_addr == DATA_ADDR))
        else $error("tx_wr without accepted data write");

    p_done_raise_r3: assert property (@(posedge clk) disable iff (rst)
        (done_rise && st_q.en_main && !enab_wr) |=> irq)
        else $error("done edge did not raise irq");

    p_stop_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (stop_fall && !st_q.en_stop && !done_rise && !req) |=> !req)
        else $error("masked stop edge raised request");

endmodule

// File: tb/tb_i2c_irq_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_irq_ctrl;

    localparam int          ADDR_W    = 16;
    localparam logic [15:0] CTRL_ADDR = 16'h0040;
    localparam logic [15:0] DATA_ADDR = 16'h0041;
    localparam logic [15:0] FLAG_ADDR = 16'h0050;
    localparam logic [15:0] ENAB_ADDR = 16'h0051;
    localparam int          REQ_BIT   = 3;

    logic clk = 1'b0;
    logic rst;
    logic bus_sel, bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic eng_done, eng_stop, eng_ack, eng_berr;
    logic [1:0] eng_id;
    logic [7:0] eng_rx_byte;
    logic cmd_start, cmd_stop, cmd_lastrd, tx_wr, rx_rd, irq;
    logic [7:0] tx_byte;

    int n_chk  = 0;
    int n_fail = 0;

    // bench model
    logic m_req, m_done, m_stop, m_enm, m_ens, m_lastrd;
    logic [7:0] m_tx;

    always #5 clk = ~clk;

    i2c_irq_ctrl #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR),
        .ENAB_ADDR(ENAB_ADDR), .REQ_BIT(REQ_BIT)
    ) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .eng_stop(eng_stop), .eng_ack(eng_ack),
        .eng_berr(eng_berr), .eng_id(eng_id), .eng_rx_byte(eng_rx_byte),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_lastrd(cmd_lastrd),
        .tx_byte(tx_byte), .tx_wr(tx_wr), .rx_rd(rx_rd), .irq(irq)
    );

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        logic [7:0] v = 8'h00;
        case (bus_addr)
            CTRL_ADDR: v = {1'b0, eng_stop, m_lastrd, eng_id, eng_berr, eng_ack, eng_done};
            DATA_ADDR: v = eng_rx_byte;
            FLAG_ADDR: v[REQ_BIT] = m_req;
            ENAB_ADDR: v = {6'b0, m_ens, m_enm};
            default:   v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic next_req();
        logic rise, fall, acc, fclr;
        rise = eng_done && !m_done;
        fall = !eng_stop && m_stop && m_ens;
        acc  = bus_sel && (bus_addr == CTRL_ADDR || bus_addr == DATA_ADDR) &&
               (!bus_we || !eng_stop);
        fclr = bus_sel && bus_we && bus_addr == FLAG_ADDR && !bus_wdata[REQ_BIT];
        if (rise || fall)     return 1'b1;
        else if (acc || fclr) return 1'b0;
        return m_req;
    endfunction

    // one clock: inputs were set just after the previous edge
    task automatic step(string tag);
        logic n_req, e_txwr, e_start, e_stop, e_rxrd, ok_wr;
        #4;
        if (bus_sel && !bus_we) chk({tag, " R2 read data"}, bus_rdata, exp_rd());
        n_req   = next_req();
        ok_wr   = bus_sel && bus_we && !eng_stop;
        e_txwr  = ok_wr && bus_addr == DATA_ADDR;
        e_start = ok_wr && bus_addr == CTRL_ADDR && bus_wdata[7];
        e_stop  = ok_wr && bus_addr == CTRL_ADDR && bus_wdata[6];
        e_rxrd  = bus_sel && !bus_we && bus_addr == DATA_ADDR;
        if (ok_wr && bus_addr == CTRL_ADDR) m_lastrd = bus_wdata[5];
        if (e_txwr) m_tx = bus_wdata;
        if (bus_sel && bus_we && bus_addr == ENAB_ADDR) begin
            m_enm = bus_wdata[0];
            m_ens = bus_wdata[1];
        end
        m_req  = n_req;
        m_done = eng_done;
        m_stop = eng_stop;
        @(posedge clk);
        #1;
        chk({tag, " irq"},         {7'b0, irq},        {7'b0, m_req & m_enm});
        chk({tag, " R10 tx_wr"},   {7'b0, tx_wr},      {7'b0, e_txwr});
        chk({tag, " R10 start"},   {7'b0, cmd_start},  {7'b0, e_start});
        chk({tag, " R10 stop"},    {7'b0, cmd_stop},   {7'b0, e_stop});
        chk({tag, " R10 rx_rd"},   {7'b0, rx_rd},      {7'b0, e_rxrd});
        chk({tag, " R9 lastrd"},   {7'b0, cmd_lastrd}, {7'b0, m_lastrd});
        chk({tag, " R9 tx_byte"},  tx_byte,            m_tx);
        bus_sel = 1'b0;
    endtask

    task automatic acc(logic we, logic [15:0] a, logic [7:0] d);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        rst = 1'b1; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        eng_done = 0; eng_stop = 0; eng_ack = 0; eng_berr = 0; eng_id = 2'b10;
        eng_rx_byte = 8'h5A;
        m_req = 0; m_done = 0; m_stop = 0; m_enm = 0; m_ens = 0; m_lastrd = 0; m_tx = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 tx_wr", {7'b0, tx_wr}, 8'h00);
        acc(0, ENAB_ADDR, 0); step("R1 enab");
        acc(0, FLAG_ADDR, 0); step("R1 flag");
        acc(0, CTRL_ADDR, 0); step("R1 R2 ctrl");

        // R3 done edge with main enable
        acc(1, ENAB_ADDR, 8'h01); step("R5 enable");
        eng_done = 1; step("R3 done rise");
        chk("R3 irq after done rise", {7'b0, irq}, 8'h01);
        acc(0, FLAG_ADDR, 0); step("R5 flag read keeps");
        chk("R5 irq kept", {7'b0, irq}, 8'h01);
        acc(0, DATA_ADDR, 0); step("R7 data read clears");
        chk("R7 irq cleared", {7'b0, irq}, 8'h00);

        // R4 stop edge, disabled then enabled
        eng_stop = 1; step("R4 stop high");
        eng_stop = 0; step("R4 stop fall masked");
        chk("R4 masked", {7'b0, irq}, 8'h00);
        acc(1, ENAB_ADDR, 8'h03); step("R4 enable stop");
        eng_stop = 1; step("R4 stop high");
        eng_stop = 0; step("R4 stop fall enabled");
        chk("R4 enabled", {7'b0, irq}, 8'h01);

        // R6 flag writes
        acc(1, FLAG_ADDR, 8'h08); step("R6 write one");
        chk("R6 write one keeps", {7'b0, irq}, 8'h01);
        acc(1, FLAG_ADDR, 8'hF7); step("R6 write zero");
        chk("R6 cleared", {7'b0, irq}, 8'h00);

        // R8 set beats clear
        eng_done = 0; step("R8 prep");
        eng_done = 1; acc(0, CTRL_ADDR, 0); step("R8 collide");
        chk("R8 set wins", {7'b0, irq}, 8'h01);

        // R5 main enable off hides request
        acc(1, ENAB_ADDR, 8'h00); step("R5 disable");
        chk("R5 irq masked", {7'b0, irq}, 8'h00);
        acc(0, FLAG_ADDR, 0); step("R5 flag still set");

        // R9 writes dropped during stop
        eng_stop = 1; step("R9 stop on");
        acc(1, DATA_ADDR, 8'hA5); step("R9 data write dropped");
        acc(1, CTRL_ADDR, 8'hE0); step("R9 ctrl write dropped");
        acc(0, FLAG_ADDR, 0); step("R9 request kept");

        // R10 accepted writes
        eng_stop = 0; step("R10 stop off");
        acc(1, DATA_ADDR, 8'h3C); step("R10 data write");
        chk("R10 tx_byte", tx_byte, 8'h3C);
        acc(1, CTRL_ADDR, 8'hE0); step("R10 ctrl write");
        acc(0, CTRL_ADDR, 0); step("R2 ctrl readback");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] addrs [5];
            addrs[0] = CTRL_ADDR; addrs[1] = DATA_ADDR; addrs[2] = FLAG_ADDR;
            addrs[3] = ENAB_ADDR; addrs[4] = 16'h0077;
            if ($urandom_range(0, 3) == 0) eng_done = ~eng_done;
            if ($urandom_range(0, 4) == 0) eng_stop = ~eng_stop;
            eng_ack = 1'($urandom); eng_berr = 1'($urandom);
            eng_id = 2'($urandom); eng_rx_byte = 8'($urandom);
            if ($urandom_range(0, 9) < 5)
                acc(1'($urandom), addrs[$urandom_range(0, 4)], 8'($urandom));
            step("R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule